// File: doc/BRIEF.md
# System Address Region Decoder

This block steers every processor access to exactly one destination. An access is either a memory access or an I/O access with a 32-bit address. The possible destinations are the SDRAM, the boot ROM, the configuration register block, the integrated legacy peripherals, the PCI configuration port, the general-purpose (GP) expansion bus and, when nothing else claims the access, the PCI bus. The decoder compares the address against fixed regions and programmable regions in a fixed priority order. It returns the chosen destination as a one-hot select, registered one clock after the access strobe.

The programmable state is held in the decoder itself. The SDRAM top, the size of the linear SDRAM region, is capped at 256 MB. Four generic windows can send a memory or I/O range to the GP bus. These registers sit at fixed offsets inside the 4 KB configuration block. The configuration block normally lives at FFFEF000h. A relocation register can give it a second home at any 4 KB boundary below 1 GB. That register is itself reached through I/O ports FFFCh to FFFFh, so software can find the block before it knows where the block is. Register reads return data on the same cycle as the select.

Top module: `addr_region_decoder`

## Requirements
- R1: One rising edge after a cycle with `acc_valid` high, `sel_valid` is high and `tgt_sel` has exactly one bit set. After a cycle without `acc_valid`, both outputs are zero. The `tgt_sel` bit encoding is:
  - bit0: SDRAM
  - bit1: boot ROM
  - bit2: configuration block
  - bit3: legacy peripherals
  - bit4: PCI configuration port
  - bit5: GP bus
  - bit6: PCI bus
- R2: Memory claims are resolved in this order: configuration block, then boot region, then GP windows, then SDRAM, then PCI. I/O claims are resolved in this order: relocation register, then PCI configuration port, then legacy peripherals, then GP windows, then PCI. An I/O access never selects bits 0 to 2 except bit2 for the relocation ports. A memory access never selects bit3 or bit4.
- R3: A memory access with an address from FFFF0000h to FFFFFFFFh selects the boot ROM.
- R4: Memory addresses FFFEF000h to FFFEFFFFh always select the configuration block. When the relocation enable (bit31) is set, the 4 KB page whose address bits 29:12 equal the stored base also selects it, for addresses with bits 31:30 zero. The enable bit is clear after reset. Register offsets are taken from address bits 11:0 at either location.
- R5: A processor I/O access to ports FFFCh to FFFFh reaches the relocation register and selects bit2. Writes store bit31 as the enable and bits 29:12 as the base. Reads return {enable, 0, base, 12'h000}. An I/O access from any other master to these ports is not claimed by the register and leaves it unchanged. Only address bits 15:0 take part in any I/O decode.
- R6: A processor I/O access to ports 0CF8h to 0CFFh selects the PCI configuration port. An I/O access from any other master to these ports falls through to the lower-priority claims.
- R7: I/O ports 0000h to 03FFh select the legacy peripherals, ahead of any GP window.
- R8: The SDRAM top register sits at configuration offset 000h and holds address bits 31:16. A write above 10000000h stores 10000000h; otherwise the write stores wdata with bits 15:0 cleared. Reset value is 04000000h. A memory access below the top, and not claimed first, selects the SDRAM.
- R9: Window n has three registers:
  - control at offset 100h+16n: bit0 enable, bit1 selects I/O.
  - base at offset 104h+16n.
  - exclusive limit at offset 108h+16n.

  A memory window claims addresses with base ≤ addr < limit and addr < 40000000h. An I/O window compares the 16-bit port, zero-extended, the same way.
- R10: Any access that no other region claims selects the PCI bus.
- R11: `rd_data` is registered alongside `tgt_sel`. It carries register contents only for a read that selected bit2, and is zero otherwise. Configuration offsets outside the map read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| acc_cpu | input | 1 | 1 = access issued by the processor |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Access address |
| acc_wdata | input | 32 | Write data for register writes |
| tgt_sel | output | 7 | Registered one-hot destination select |
| sel_valid | output | 1 | Registered copy of the access strobe |
| rd_data | output | 32 | Registered register read data |

## Verification
The select, the valid flag and the read data are all due at the first rising edge after the strobe. The bench samples them at the following falling edge: each directed access is driven on a falling edge and checked one falling edge later, against a hand-worked literal value. A register write changes the decode only for accesses strobed from the next cycle onward, and the directed sequences always re-read or re-decode after a write. In parallel, a behavioural model captures the inputs at every rising edge and predicts the outputs seen at the next falling edge, so idle cycles are checked for all-zero outputs as well.

// File: rtl/ard_pkg.sv
// Shared constants and types for the address region decoder.
// Assumes a 32-bit address space with 16-bit I/O ports.
package ard_pkg;

    localparam int TGT_N      = 7;
    localparam int TGT_SDRAM  = 0;
    localparam int TGT_BOOT   = 1;
    localparam int TGT_CFG    = 2;
    localparam int TGT_LEGACY = 3;
    localparam int TGT_PCICFG = 4;
    localparam int TGT_GP     = 5;
    localparam int TGT_PCI    = 6;

    typedef logic [TGT_N-1:0] tgt_vec_t;

    // Fixed regions
    localparam logic [19:0] CFG_DEF_PAGE   = 20'hFFFEF;
    localparam logic [15:0] BOOT_PAGE64K   = 16'hFFFF;
    localparam logic [13:0] RELOC_PORT_DW  = 14'h3FFF;   // FFFCh..FFFFh
    localparam logic [12:0] PCICFG_PORT_QW = 13'h019F;   // 0CF8h..0CFFh
    localparam logic [15:0] LEGACY_END     = 16'h0400;
    localparam logic [31:0] GP_MEM_CEIL    = 32'h4000_0000;

    // Configuration block layout
    localparam logic [11:0] OFF_DRAM_TOP   = 12'h000;
    localparam logic [3:0]  OFF_WIN_BANK   = 4'h1;
    localparam logic [3:0]  WSUB_CTRL      = 4'h0;
    localparam logic [3:0]  WSUB_BASE      = 4'h4;
    localparam logic [3:0]  WSUB_LIM       = 4'h8;

    localparam int RELOC_BASE_W = 18;

    typedef struct packed {
        logic        en;
        logic        io;
        logic [31:0] base;
        logic [31:0] lim;
    } win_t;

endpackage

// File: rtl/ard_regs.sv
// Register file of the decoder: SDRAM top, relocation register and
// generic window registers. Assumes NUM_WIN <= 16 (one 16-byte slot each
// inside offsets 100h..1FFh). Writes are single full-word strobes.
module ard_regs
    import ard_pkg::*;
#(
    parameter int          NUM_WIN   = 4,
    parameter logic [31:0] DRAM_MAX  = 32'h1000_0000,
    parameter logic [31:0] DRAM_RST  = 32'h0400_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [11:0]             cfg_off,
    input  logic                    reloc_wr,
    input  logic [31:0]             wdata,
    output logic [31:0]             dram_top,
    output logic                    reloc_en,
    output logic [RELOC_BASE_W-1:0] reloc_base,
    output win_t                    wins [NUM_WIN],
    output logic [31:0]             cfg_rdata,
    output logic [31:0]             reloc_rdata
);

    logic [15:0]             top_q;
    logic                    reloc_en_q;
    logic [RELOC_BASE_W-1:0] reloc_base_q;
    win_t                    win_q [NUM_WIN];
    logic [15:0]             top_clamped;

    // Clamp an SDRAM top write to the maximum size
    always_comb begin
        if (wdata > DRAM_MAX) top_clamped = DRAM_MAX[31:16];
        else                  top_clamped = wdata[31:16];
    end

    // SDRAM top and relocation register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q        <= DRAM_RST[31:16];
            reloc_en_q   <= 1'b0;
            reloc_base_q <= '0;
        end else begin
            if (cfg_wr && cfg_off == OFF_DRAM_TOP) top_q <= top_clamped;
            if (reloc_wr) begin
                reloc_en_q   <= wdata[31];
                reloc_base_q <= wdata[29:12];
            end
        end
    end

    // One register slot per window
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic slot_hit;
        assign slot_hit = cfg_wr && (cfg_off[11:8] == OFF_WIN_BANK)
                          && (cfg_off[7:4] == 4'(g));

        // Window register update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_q[g] <= '0;
            end else if (slot_hit) begin
                case (cfg_off[3:0])
                    WSUB_CTRL: begin
                        win_q[g].en <= wdata[0];
                        win_q[g].io <= wdata[1];
                    end
                    WSUB_BASE: win_q[g].base <= wdata;
                    WSUB_LIM:  win_q[g].lim  <= wdata;
                    default:   ;
                endcase
            end
        end
        assign wins[g] = win_q[g];
    end

    // Configuration block read mux
    always_comb begin
        cfg_rdata = '0;
        if (cfg_off == OFF_DRAM_TOP) cfg_rdata = {top_q, 16'h0000};
        for (int i = 0; i < NUM_WIN; i++) begin
            if (cfg_off[11:8] == OFF_WIN_BANK && cfg_off[7:4] == 4'(i)) begin
                case (cfg_off[3:0])
                    WSUB_CTRL: cfg_rdata = {30'd0, win_q[i].io, win_q[i].en};
                    WSUB_BASE: cfg_rdata = win_q[i].base;
                    WSUB_LIM:  cfg_rdata = win_q[i].lim;
                    default:   cfg_rdata = '0;
                endcase
            end
        end
    end

    assign dram_top    = {top_q, 16'h0000};
    assign reloc_en    = reloc_en_q;
    assign reloc_base  = reloc_base_q;
    assign reloc_rdata = {reloc_en_q, 1'b0, reloc_base_q, 12'h000};

endmodule

// File: rtl/ard_win_match.sv
// Compares one address against all generic windows of one kind.
// WANT_IO picks the I/O variant (address is a zero-extended port) or the
// memory variant (address must also lie below the 1 GB ceiling).
module ard_win_match
    import ard_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter bit WANT_IO = 1'b0
) (
    input  win_t        wins [NUM_WIN],
    input  logic [31:0] addr,
    output logic        hit
);

    logic [NUM_WIN-1:0] hits;
    logic               in_space;

    // Space limit for this kind of window
    if (WANT_IO) begin : g_io
        assign in_space = 1'b1;
    end else begin : g_mem
        assign in_space = addr < GP_MEM_CEIL;
    end

    // Per-window range compare
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign hits[g] = wins[g].en && (wins[g].io == WANT_IO)
                         && (addr >= wins[g].base) && (addr < wins[g].lim);
    end

    assign hit = in_space && (|hits);

endmodule

// File: rtl/ard_mem_decode.sv
// Memory-space claim resolution. Produces a one-hot destination with PCI
// as the fall-through. Assumes the register values are stable this cycle.
module ard_mem_decode
    import ard_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic [31:0]             addr,
    input  logic [31:0]             dram_top,
    input  logic                    reloc_en,
    input  logic [RELOC_BASE_W-1:0] reloc_base,
    input  win_t                    wins [NUM_WIN],
    output tgt_vec_t                claim
);

    logic cfg_hit, boot_hit, gp_hit, dram_hit;

    ard_win_match #(.NUM_WIN(NUM_WIN), .WANT_IO(1'b0)) u_gp (
        .wins (wins),
        .addr (addr),
        .hit  (gp_hit)
    );

    // Raw region hits
    always_comb begin
        cfg_hit  = (addr[31:12] == CFG_DEF_PAGE)
                   || (reloc_en && addr[31:30] == 2'b00 && addr[29:12] == reloc_base);
        boot_hit = addr[31:16] == BOOT_PAGE64K;
        dram_hit = addr < dram_top;
    end

    // Fixed priority resolution
    always_comb begin
        claim = '0;
        if (cfg_hit)       claim[TGT_CFG]   = 1'b1;
        else if (boot_hit) claim[TGT_BOOT]  = 1'b1;
        else if (gp_hit)   claim[TGT_GP]    = 1'b1;
        else if (dram_hit) claim[TGT_SDRAM] = 1'b1;
        else               claim[TGT_PCI]   = 1'b1;
    end

endmodule

// File: rtl/ard_io_decode.sv
// I/O-space claim resolution on a 16-bit port. Processor-only regions are
// skipped for other masters. PCI is the fall-through.
module ard_io_decode
    import ard_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic [15:0] port,
    input  logic        cpu,
    input  win_t        wins [NUM_WIN],
    output tgt_vec_t    claim
);

    logic reloc_hit, pcicfg_hit, legacy_hit, gp_hit;

    ard_win_match #(.NUM_WIN(NUM_WIN), .WANT_IO(1'b1)) u_gp (
        .wins (wins),
        .addr ({16'h0000, port}),
        .hit  (gp_hit)
    );

    // Raw port hits
    always_comb begin
        reloc_hit  = cpu && (port[15:2] == RELOC_PORT_DW);
        pcicfg_hit = cpu && (port[15:3] == PCICFG_PORT_QW);
        legacy_hit = port < LEGACY_END;
    end

    // Fixed priority resolution
    always_comb begin
        claim = '0;
        if (reloc_hit)       claim[TGT_CFG]    = 1'b1;
        else if (pcicfg_hit) claim[TGT_PCICFG] = 1'b1;
        else if (legacy_hit) claim[TGT_LEGACY] = 1'b1;
        else if (gp_hit)     claim[TGT_GP]     = 1'b1;
        else                 claim[TGT_PCI]    = 1'b1;
    end

endmodule

// File: rtl/addr_region_decoder.sv
// Top of the system address region decoder. Each strobed access is decoded
// in the strobe cycle and the one-hot destination plus any register read
// data appear one clock later. Register writes land on the same edge.
module addr_region_decoder
    import ard_pkg::*;
#(
    parameter int          NUM_WIN  = 4,
    parameter logic [31:0] DRAM_MAX = 32'h1000_0000,
    parameter logic [31:0] DRAM_RST = 32'h0400_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_is_io,
    input  logic        acc_cpu,
    input  logic        acc_write,
    input  logic [31:0] acc_addr,
    input  logic [31:0] acc_wdata,
    output logic [6:0]  tgt_sel,
    output logic        sel_valid,
    output logic [31:0] rd_data
);

    logic [31:0]             dram_top;
    logic                    reloc_en;
    logic [RELOC_BASE_W-1:0] reloc_base;
    win_t                    wins [NUM_WIN];
    logic [31:0]             cfg_rdata, reloc_rdata;
    tgt_vec_t                mem_claim, io_claim, claim;
    logic                    cfg_wr, reloc_wr;
    logic [31:0]             rd_next;
    tgt_vec_t                sel_q;
    logic                    vld_q;
    logic [31:0]             rd_q;

    ard_regs #(.NUM_WIN(NUM_WIN), .DRAM_MAX(DRAM_MAX), .DRAM_RST(DRAM_RST)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_off     (acc_addr[11:0]),
        .reloc_wr    (reloc_wr),
        .wdata       (acc_wdata),
        .dram_top    (dram_top),
        .reloc_en    (reloc_en),
        .reloc_base  (reloc_base),
        .wins        (wins),
        .cfg_rdata   (cfg_rdata),
        .reloc_rdata (reloc_rdata)
    );

    ard_mem_decode #(.NUM_WIN(NUM_WIN)) u_mem (
        .addr       (acc_addr),
        .dram_top   (dram_top),
        .reloc_en   (reloc_en),
        .reloc_base (reloc_base),
        .wins       (wins),
        .claim      (mem_claim)
    );

    ard_io_decode #(.NUM_WIN(NUM_WIN)) u_io (
        .port  (acc_addr[15:0]),
        .cpu   (acc_cpu),
        .wins  (wins),
        .claim (io_claim)
    );

    // Pick the space, derive register strobes and read data
    always_comb begin
        claim    = acc_is_io ? io_claim : mem_claim;
        cfg_wr   = acc_valid && acc_write && !acc_is_io && claim[TGT_CFG];
        reloc_wr = acc_valid && acc_write &&  acc_is_io && claim[TGT_CFG];
        rd_next  = '0;
        if (acc_valid && !acc_write && claim[TGT_CFG])
            rd_next = acc_is_io ? reloc_rdata : cfg_rdata;
    end

    // Output registers, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            vld_q <= 1'b0;
            rd_q  <= '0;
        end else begin
            sel_q <= acc_valid ? claim : '0;
            vld_q <= acc_valid;
            rd_q  <= rd_next;
        end
    end

    assign tgt_sel   = sel_q;
    assign sel_valid = vld_q;
    assign rd_data   = rd_q;

endmodule

// File: rtl/ard_checker.sv
// Port-level properties of the address region decoder, bound to the top.
module ard_checker
    import ard_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_is_io,
    input logic        acc_cpu,
    input logic [31:0] acc_addr,
    input logic [6:0]  tgt_sel,
    input logic        sel_valid,
    input logic [31:0] rd_data
);

    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> $countones(tgt_sel) == 1);

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> tgt_sel == '0);

    assert_strobe_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> sel_valid);

    assert_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !sel_valid);

    assert_io_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_io) |=> !tgt_sel[TGT_SDRAM] && !tgt_sel[TGT_BOOT]);

    assert_mem_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_io) |=> !tgt_sel[TGT_LEGACY] && !tgt_sel[TGT_PCICFG]);

    assert_boot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_io && acc_addr[31:16] == 16'hFFFF) |=> tgt_sel[TGT_BOOT]);

    assert_cfg_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_io && acc_addr[31:12] == 20'hFFFEF) |=> tgt_sel[TGT_CFG]);

    assert_reloc_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_io && acc_cpu && acc_addr[15:2] == 14'h3FFF) |=> tgt_sel[TGT_CFG]);

    assert_pcicfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_io && acc_cpu && acc_addr[15:3] == 13'h019F) |=> tgt_sel[TGT_PCICFG]);

    assert_pcicfg_cpu_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_cpu) |=> !tgt_sel[TGT_PCICFG]);

    assert_legacy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_io && acc_addr[15:10] == 6'd0) |=> tgt_sel[TGT_LEGACY]);

    assert_rd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_sel[TGT_CFG] |-> rd_data == '0);

endmodule

bind addr_region_decoder ard_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_is_io (acc_is_io),
    .acc_cpu   (acc_cpu),
    .acc_addr  (acc_addr),
    .tgt_sel   (tgt_sel),
    .sel_valid (sel_valid),
    .rd_data   (rd_data)
);

// File: tb/sim_addr_region_decoder.sv
// Bench: directed accesses with hand-worked results plus a behavioural
// model compared on every falling edge.
module sim_addr_region_decoder;

    localparam int SDRAM = 0, BOOT = 1, CFG = 2, LEG = 3, PCFG = 4, GP = 5, PCI = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_is_io = 1'b0, acc_cpu = 1'b1, acc_write = 1'b0;
    logic [31:0] acc_addr = '0, acc_wdata = '0;
    logic [6:0]  tgt_sel;
    logic        sel_valid;
    logic [31:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    always #5 clk = ~clk;

    addr_region_decoder u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_io(acc_is_io),
        .acc_cpu(acc_cpu), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .tgt_sel(tgt_sel), .sel_valid(sel_valid),
        .rd_data(rd_data)
    );

    // Behavioural model state
    logic [31:0] m_top = 32'h0400_0000;
    bit          m_al_en = 1'b0;
    logic [31:0] m_al_addr = '0;
    logic [1:0]  m_wctl [4];
    logic [31:0] m_wbase [4];
    logic [31:0] m_wlim [4];
    logic [6:0]  e_sel = '0;
    logic        e_vld = 1'b0;
    logic [31:0] e_rd = '0;
    int          e_tgt = 0;

    function automatic string tag_of(input int t);
        case (t)
            SDRAM: return "R8";
            BOOT:  return "R3";
            CFG:   return "R4";
            LEG:   return "R7";
            PCFG:  return "R6";
            GP:    return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic bit win_hit(input bit io, input logic [31:0] x);
        for (int w = 0; w < 4; w++)
            if (m_wctl[w][0] && m_wctl[w][1] == io && x >= m_wbase[w] && x < m_wlim[w]
                && (io || x < 32'h4000_0000))
                return 1'b1;
        return 1'b0;
    endfunction

    function automatic int exp_tgt(input bit io, input bit cpu, input logic [31:0] a);
        logic [31:0] p;
        p = {16'h0, a[15:0]};
        if (!io) begin
            if (a >= 32'hFFFE_F000 && a <= 32'hFFFE_FFFF) return CFG;
            if (m_al_en && a >= m_al_addr && a < m_al_addr + 32'h1000) return CFG;
            if (a >= 32'hFFFF_0000) return BOOT;
            if (win_hit(1'b0, a)) return GP;
            if (a < m_top) return SDRAM;
            return PCI;
        end
        if (cpu && p >= 32'hFFFC) return CFG;
        if (cpu && p >= 32'h0CF8 && p <= 32'h0CFF) return PCFG;
        if (p < 32'h0400) return LEG;
        if (win_hit(1'b1, p)) return GP;
        return PCI;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] off);
        if (off == 12'h000) return m_top;
        for (int w = 0; w < 4; w++) begin
            if (off == 12'h100 + 12'(16 * w)) return {30'd0, m_wctl[w]};
            if (off == 12'h104 + 12'(16 * w)) return m_wbase[w];
            if (off == 12'h108 + 12'(16 * w)) return m_wlim[w];
        end
        return 32'h0;
    endfunction

    task automatic m_write(input logic [11:0] off, input logic [31:0] d);
        if (off == 12'h000) m_top = (d > 32'h1000_0000) ? 32'h1000_0000 : {d[31:16], 16'h0};
        for (int w = 0; w < 4; w++) begin
            if (off == 12'h100 + 12'(16 * w)) m_wctl[w] = d[1:0];
            if (off == 12'h104 + 12'(16 * w)) m_wbase[w] = d;
            if (off == 12'h108 + 12'(16 * w)) m_wlim[w] = d;
        end
    endtask

    // Model: capture inputs at each rising edge, predict next outputs
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_top = 32'h0400_0000; m_al_en = 1'b0; m_al_addr = '0;
            for (int w = 0; w < 4; w++) begin
                m_wctl[w] = '0; m_wbase[w] = '0; m_wlim[w] = '0;
            end
            e_sel = '0; e_vld = 1'b0; e_rd = '0;
        end else if (acc_valid) begin
            e_tgt = exp_tgt(acc_is_io, acc_cpu, acc_addr);
            e_sel = 7'(1 << e_tgt);
            e_vld = 1'b1;
            e_rd  = '0;
            if (e_tgt == CFG) begin
                if (!acc_write)
                    e_rd = acc_is_io ? {m_al_en, 1'b0, m_al_addr[29:12], 12'h0}
                                     : m_read(acc_addr[11:0]);
                else if (acc_is_io) begin
                    m_al_en = acc_wdata[31];
                    m_al_addr = {2'b00, acc_wdata[29:12], 12'h0};
                end else
                    m_write(acc_addr[11:0], acc_wdata);
            end
        end else begin
            e_sel = '0; e_vld = 1'b0; e_rd = '0;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            n_vec++;
            if (sel_valid !== e_vld || tgt_sel !== e_sel) begin
                n_bad++;
                $display("FAIL R1/%s model: sel=%b vld=%b expected sel=%b vld=%b",
                         tag_of(e_tgt), tgt_sel, sel_valid, e_sel, e_vld);
            end
            if (rd_data !== e_rd) begin
                n_bad++;
                $display("FAIL R11 model: rd_data=%h expected %h", rd_data, e_rd);
            end
        end
    end

    task automatic acc(input bit io, input bit cpu, input bit wr, input logic [31:0] a,
                       input logic [31:0] d, input int et, input logic [31:0] er,
                       input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_is_io = io; acc_cpu = cpu; acc_write = wr;
        acc_addr = a; acc_wdata = d;
        @(negedge clk);
        n_vec++;
        if (tgt_sel !== 7'(1 << et) || sel_valid !== 1'b1 || rd_data !== er) begin
            n_bad++;
            $display("FAIL %s addr=%h io=%0d: sel=%b rd=%h expected sel=%b rd=%h",
                     tag, a, io, tgt_sel, rd_data, 7'(1 << et), er);
        end
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic cfgw(input logic [11:0] off, input logic [31:0] d);
        acc(1'b0, 1'b1, 1'b1, {20'hFFFEF, off}, d, CFG, 32'h0, "R9 write");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (tgt_sel !== 7'd0 || sel_valid !== 1'b0 || rd_data !== 32'd0) begin
            n_bad++;
            $display("FAIL R1 reset: sel=%b vld=%b rd=%h expected 0 0 0", tgt_sel, sel_valid, rd_data);
        end
        rst_n = 1'b1;

        // Reset register values
        acc(0, 1, 0, 32'hFFFE_F000, 0, CFG, 32'h0400_0000, "R8 reset top");
        acc(1, 1, 0, 32'h0000_FFFC, 0, CFG, 32'h0, "R5 reset reloc");
        // SDRAM and PCI fall-through
        acc(0, 1, 0, 32'h0000_0000, 0, SDRAM, 0, "R8");
        acc(0, 1, 0, 32'h03FF_FFFF, 0, SDRAM, 0, "R8");
        acc(0, 1, 0, 32'h0400_0000, 0, PCI, 0, "R10");
        acc(0, 1, 0, 32'h0000_0CF8, 0, SDRAM, 0, "R2 mem not io");
        // Boot and default configuration block
        acc(0, 1, 0, 32'hFFFF_0000, 0, BOOT, 0, "R3");
        acc(0, 1, 0, 32'hFFFF_FFFF, 0, BOOT, 0, "R3");
        acc(0, 1, 0, 32'hFFFE_FFFF, 0, CFG, 0, "R4");
        acc(0, 1, 0, 32'hFFFE_EFFF, 0, PCI, 0, "R10");
        // I/O fixed ports
        acc(1, 1, 0, 32'h0000_0000, 0, LEG, 0, "R7");
        acc(1, 1, 0, 32'h0000_03FF, 0, LEG, 0, "R7");
        acc(1, 1, 0, 32'h0000_0400, 0, PCI, 0, "R10");
        acc(1, 1, 0, 32'h0000_0CF7, 0, PCI, 0, "R10");
        acc(1, 1, 0, 32'h0000_0CF8, 0, PCFG, 0, "R6");
        acc(1, 1, 0, 32'h0000_0CFF, 0, PCFG, 0, "R6");
        acc(1, 1, 0, 32'h1234_0CF8, 0, PCFG, 0, "R6 upper bits ignored");
        acc(1, 1, 0, 32'h0000_0D00, 0, PCI, 0, "R10");
        acc(1, 0, 0, 32'h0000_0CF8, 0, PCI, 0, "R6 non-cpu");
        acc(1, 0, 0, 32'h0000_FFFC, 0, PCI, 0, "R5 non-cpu");
        // SDRAM top clamp and granularity
        cfgw(12'h000, 32'h2000_0000);
        acc(0, 1, 0, 32'hFFFE_F000, 0, CFG, 32'h1000_0000, "R8 clamp");
        acc(0, 1, 0, 32'h0FFF_FFFF, 0, SDRAM, 0, "R8");
        acc(0, 1, 0, 32'h1000_0000, 0, PCI, 0, "R8 top");
        cfgw(12'h000, 32'h0800_1234);
        acc(0, 1, 0, 32'hFFFE_F000, 0, CFG, 32'h0800_0000, "R8 granule");
        acc(0, 1, 0, 32'h07FF_FFFF, 0, SDRAM, 0, "R8");
        acc(0, 1, 0, 32'h0800_0000, 0, PCI, 0, "R8 top");
        cfgw(12'h000, 32'h1000_0000);
        // Relocation register
        acc(0, 1, 0, 32'h0123_4000, 0, SDRAM, 0, "R4 reloc off");
        acc(1, 1, 1, 32'h0000_FFFC, 32'h8123_4000, CFG, 0, "R5 write");
        acc(1, 1, 0, 32'h0000_FFFE, 0, CFG, 32'h8123_4000, "R5 read");
        acc(0, 1, 0, 32'h0123_4000, 0, CFG, 32'h1000_0000, "R4 reloc on");
        acc(0, 1, 0, 32'h0123_4FFF, 0, CFG, 0, "R4 reloc page end");
        acc(0, 1, 0, 32'h0123_5000, 0, SDRAM, 0, "R4 next page");
        acc(0, 1, 0, 32'hFFFE_F000, 0, CFG, 32'h1000_0000, "R4 default kept");
        acc(1, 0, 1, 32'h0000_FFFC, 32'h0, PCI, 0, "R5 non-cpu write");
        acc(1, 1, 0, 32'h0000_FFFC, 0, CFG, 32'h8123_4000, "R5 unchanged");
        acc(1, 1, 1, 32'h0000_FFFF, 32'hC123_4000, CFG, 0, "R5 write");
        acc(1, 1, 0, 32'h0000_FFFD, 0, CFG, 32'h8123_4000, "R5 bit30 dropped");
        acc(1, 1, 1, 32'h0000_FFFC, 32'h0123_4000, CFG, 0, "R5 disable");
        acc(1, 1, 0, 32'h0000_FFFC, 0, CFG, 32'h0123_4000, "R5 read");
        acc(0, 1, 0, 32'h0123_4000, 0, SDRAM, 0, "R4 reloc off");
        // Generic windows
        cfgw(12'h100, 32'h1); cfgw(12'h104, 32'h0200_0000); cfgw(12'h108, 32'h0300_0000);
        acc(0, 1, 0, 32'hFFFE_F100, 0, CFG, 32'h1, "R9 ctrl read");
        acc(0, 1, 0, 32'hFFFE_F104, 0, CFG, 32'h0200_0000, "R9 base read");
        acc(0, 1, 0, 32'h0250_0000, 0, GP, 0, "R2 gp over sdram");
        acc(0, 1, 0, 32'h02FF_FFFF, 0, GP, 0, "R9");
        acc(0, 1, 0, 32'h0300_0000, 0, SDRAM, 0, "R9 limit");
        acc(0, 1, 0, 32'h01FF_FFFF, 0, SDRAM, 0, "R9 below base");
        cfgw(12'h110, 32'h3); cfgw(12'h114, 32'h300); cfgw(12'h118, 32'h500);
        acc(1, 1, 0, 32'h0000_0350, 0, LEG, 0, "R7 over gp");
        acc(1, 1, 0, 32'h0000_0450, 0, GP, 0, "R9 io");
        acc(1, 1, 0, 32'h0000_0500, 0, PCI, 0, "R9 io limit");
        acc(0, 1, 0, 32'h0000_0450, 0, SDRAM, 0, "R9 io window not mem");
        cfgw(12'h120, 32'h1); cfgw(12'h124, 32'h3FFF_0000); cfgw(12'h128, 32'hFFFF_FFFF);
        acc(0, 1, 0, 32'h3FFF_F000, 0, GP, 0, "R9 below ceiling");
        acc(0, 1, 0, 32'h4000_0000, 0, PCI, 0, "R9 ceiling");
        acc(0, 1, 0, 32'hFFFF_0000, 0, BOOT, 0, "R3 over gp");
        acc(0, 1, 0, 32'h3FFE_FFFF, 0, PCI, 0, "R10");
        cfgw(12'h130, 32'h3); cfgw(12'h134, 32'h0CF0); cfgw(12'h138, 32'h0D00);
        acc(1, 1, 0, 32'h0000_0CF4, 0, GP, 0, "R9 io");
        acc(1, 1, 0, 32'h0000_0CF8, 0, PCFG, 0, "R6 over gp");
        acc(1, 0, 0, 32'h0000_0CF8, 0, GP, 0, "R6 non-cpu falls to gp");
        acc(0, 1, 0, 32'hFFFE_F130, 0, CFG, 32'h3, "R9 ctrl read");
        // Unmapped offsets
        cfgw(12'h050, 32'hDEAD_BEEF);
        acc(0, 1, 0, 32'hFFFE_F050, 0, CFG, 32'h0, "R11 unmapped");
        acc(0, 1, 0, 32'hFFFE_F10C, 0, CFG, 32'h0, "R11 unmapped");
        // Relocated block over a window
        acc(1, 1, 1, 32'h0000_FFFC, 32'h8250_0000, CFG, 0, "R5 write");
        acc(0, 1, 0, 32'h0250_0000, 0, CFG, 32'h1000_0000, "R2 cfg over gp");
        acc(0, 1, 0, 32'h0251_0000, 0, GP, 0, "R2");
        cfgw(12'h100, 32'h0);
        acc(0, 1, 0, 32'h0260_0000, 0, SDRAM, 0, "R9 disabled");

        // Random reads against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            int k;
            k = int'($urandom % 6);
            case (k)
                0: a = $urandom;
                1: a = {20'hFFFEF, 12'($urandom)};
                2: a = {16'hFFFF, 16'($urandom)};
                3: a = {2'b00, 30'($urandom)};
                4: a = {16'($urandom), 16'($urandom % 16'h0600)};
                default: a = 32'h0CF0 + ($urandom % 32) + {16'($urandom), 16'h0};
            endcase
            @(negedge clk);
            acc_valid = ($urandom % 4) != 0;
            acc_is_io = k >= 4 ? 1'b1 : ($urandom % 5 == 0);
            acc_cpu   = ($urandom % 4) != 0;
            acc_write = 1'b0;
            acc_addr  = a;
        end
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R1 watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule